// File: doc/BRIEF.md
# Conversion Result Byte-Serial Readout Buffer

This block queues 12-bit conversion results and hands them to a host over a chip-select-framed serial link, one byte at a time with the most significant bit first. Each result occupies a 16-bit slot: a high byte carrying four zero bits above the top four result bits, then a low byte with the remaining eight bits. A separate single-entry slot holds the latest temperature reading, a 12-bit two's complement value scaled at 8 LSB per degree Celsius. A pending temperature reading jumps ahead of queued conversion data.

The serial pins are oversampled in the block's clock domain through a two-stage synchronizer. A byte counts as consumed as soon as the host clocks its first bit. A read cut short therefore loses the rest of that byte and never repeats it. A two-bit edge-mode input selects the SCLK edge that launches the next DOUT bit.

Top module: `result_byte_fifo`

## Requirements
- R1: Each entry is sent as two bytes, MSB first: the high byte is {4'b0000, data[11:8]} and the low byte is data[7:0].
- R2: If chip select rises after at least one but fewer than eight bits of an entry's high byte, the next read starts with that entry's low byte.
- R3: Once the low byte of an entry has received at least one sample edge, the entry is removed, whether or not all eight bits were clocked. The next byte read is the high byte of the following entry.
- R4: At each entry boundary, a pending temperature reading is sent before any queued conversion result.
- R5: A temperature write replaces an unread earlier reading. After the reading has been sent once, it is no longer pending.
- R6: With edge_mode = 2'b11, DOUT advances on rising SCLK edges. With any other edge_mode value, it advances on falling edges. DOUT holds its value across the opposite (sampling) edge.
- R7: A result write to a buffer holding DEPTH entries is dropped and sets a sticky overflow flag, and the level stays at DEPTH. The default DEPTH is 514.
- R8: A read from an empty buffer with no pending temperature returns zero bits and does not change the level.
- R9: DOUT is 0 whenever chip select is high.
- R10: After reset, level = 0, overflow = 0 and DOUT = 0. Level then equals the number of queued conversion results.
- R11: A chip-select frame with no SCLK edges consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SCLK and CS are oversampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_wr | input | 1 | Conversion result write strobe |
| res_data | input | 12 | Conversion result |
| temp_wr | input | 1 | Temperature result write strobe |
| temp_data | input | 12 | Temperature result, two's complement, 8 LSB/°C |
| cs_n | input | 1 | Active-low chip select framing a read |
| sclk | input | 1 | Serial clock from the host |
| edge_mode | input | 2 | 2'b11: launch on rising SCLK; otherwise launch on falling SCLK |
| dout | output | 1 | Serial data out, 0 while chip select is high |
| level | output | $clog2(DEPTH+1) | Number of queued conversion results |
| overflow | output | 1 | Sticky flag set by a write to a full buffer |

## Verification
On every cycle, the embedded properties check these rules:
- the bit counter stays within a byte;
- DOUT stays steady unless a launch edge, a byte load or a chip-select change occurs;
- the high-to-low byte stepping follows each consumed byte;
- a full buffer holds its level and the overflow flag stays set;
- a temperature write leaves a reading pending.

Only the bench scenarios can show the following:
- which bytes actually appear on the wire after a cut-short read;
- how temperature priority orders the output against queued results;
- that an overwritten temperature reading is never sent;
- that each edge-mode value launches on the intended SCLK edge.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_FIFO, SRC_TEMP} src_e;

  // high byte carries four zero bits above the top nibble
  function automatic logic [7:0] entry_byte(input logic [11:0] v, input logic lo);
    return lo ? v[7:0] : {4'b0000, v[11:8]};
  endfunction

  function automatic logic launch_on_rise(input logic [1:0] m);
    return (m == 2'b11);
  endfunction
endpackage

// File: rtl/rfifo_store.sv
module rfifo_store #(
  parameter int W     = 12,
  parameter int DEPTH = 514
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, accept, take;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign accept = wr && !full;
  assign take   = pop && !empty;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (accept) wr_ptr <= next_ptr(wr_ptr);
      if (take)   rd_ptr <= next_ptr(rd_ptr);
      if (accept && !take)      level <= level + 1'b1;
      else if (take && !accept) level <= level - 1'b1;
      if (wr && full) ovf <= 1'b1;
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr && !pop |=> level == $past(level));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !wr |=> empty);
endmodule

// File: rtl/rfifo_edge_front.sv
module rfifo_edge_front #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [1:0] mode,
  output logic       cs_act,
  output logic       frame_start,
  output logic       launch_ev,
  output logic       sample_ev
);
  import rfifo_pkg::*;

  logic [SYNC-1:0] cs_q, sclk_q;
  logic            cs_d, sclk_d, cs_s, sclk_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      sclk_q <= '0;
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      sclk_q <= {sclk_q[SYNC-2:0], sclk};
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_s        = cs_q[SYNC-1];
  assign sclk_s      = sclk_q[SYNC-1];
  assign cs_act      = ~cs_s;
  assign rise        = sclk_s & ~sclk_d;
  assign fall        = ~sclk_s & sclk_d;
  assign frame_start = cs_d & ~cs_s;
  assign launch_ev   = cs_act & ~frame_start & (launch_on_rise(mode) ? rise : fall);
  assign sample_ev   = cs_act & ~frame_start & (launch_on_rise(mode) ? fall : rise);
endmodule

// File: rtl/rfifo_byte_tx.sv
module rfifo_byte_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       launch_ev,
  input  logic       sample_ev,
  output logic       dout,
  output logic       byte_start,
  output logic       byte_full
);
  logic [7:0] shreg;
  logic [3:0] cnt;

  assign byte_start = cs_act && sample_ev && (cnt == 4'd0);
  assign byte_full  = (cnt == 4'd8);
  assign dout       = cs_act & shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!cs_act) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (load) begin
      shreg <= load_byte;
      cnt   <= '0;
    end else begin
      if (launch_ev && cnt != 4'd0) shreg <= {shreg[6:0], 1'b0};
      if (sample_ev && cnt != 4'd8) cnt <= cnt + 1'b1;
    end
  end

  assert_bitcnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);
  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act && !load && !launch_ev |=> !cs_act || $stable(dout));
endmodule

// File: rtl/result_byte_fifo.sv
module result_byte_fifo #(
  parameter int DEPTH = 514
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       res_wr,
  input  logic [11:0]                res_data,
  input  logic                       temp_wr,
  input  logic [11:0]                temp_data,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic [1:0]                 edge_mode,
  output logic                       dout,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       overflow
);
  import rfifo_pkg::*;

  localparam int W = 12;

  logic         cs_act, frame_start, launch_ev, sample_ev;
  logic         byte_start, byte_full, load, pop, empty;
  logic [W-1:0] head, temp_val, cur_val;
  logic         temp_pend, sel_lo;
  src_e         src, cur_src;

  rfifo_edge_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mode(edge_mode),
    .cs_act(cs_act), .frame_start(frame_start),
    .launch_ev(launch_ev), .sample_ev(sample_ev)
  );

  rfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(res_wr), .wdata(res_data), .pop(pop),
    .head(head), .level(level), .empty(empty), .ovf(overflow)
  );

  // entry source: chosen afresh at each entry boundary, held across its low byte
  always_comb begin
    if (!sel_lo) cur_src = temp_pend ? SRC_TEMP : (!empty ? SRC_FIFO : SRC_NONE);
    else         cur_src = src;
    case (cur_src)
      SRC_TEMP: cur_val = temp_val;
      SRC_FIFO: cur_val = head;
      default:  cur_val = '0;
    endcase
  end

  assign load = frame_start | (launch_ev & byte_full);
  assign pop  = byte_start & sel_lo & (src == SRC_FIFO);

  rfifo_byte_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .load(load),
    .load_byte(entry_byte(cur_val, sel_lo)),
    .launch_ev(launch_ev), .sample_ev(sample_ev),
    .dout(dout), .byte_start(byte_start), .byte_full(byte_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo    <= 1'b0;
      src       <= SRC_NONE;
      temp_val  <= '0;
      temp_pend <= 1'b0;
    end else begin
      if (load && !sel_lo) src <= cur_src;
      if (byte_start) sel_lo <= ~sel_lo;
      if (temp_wr) begin
        temp_val  <= temp_data;
        temp_pend <= 1'b1;
      end else if (byte_start && sel_lo && src == SRC_TEMP) begin
        temp_pend <= 1'b0;
      end
    end
  end

  assert_hi_to_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_start && !sel_lo |=> sel_lo);
  assert_lo_retires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_start && sel_lo |=> !sel_lo);
  assert_temp_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    temp_wr |=> temp_pend);
endmodule

// File: tb/result_byte_fifo_bench.sv
module result_byte_fifo_bench;
  localparam int DEPTH = 514;
  localparam int LW    = $clog2(DEPTH+1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_wr = 1'b0, temp_wr = 1'b0;
  logic [11:0]   res_data = '0, temp_data = '0;
  logic          cs_n = 1'b1, sclk = 1'b0;
  logic [1:0]    edge_mode = 2'b00;
  logic          dout, overflow;
  logic [LW-1:0] level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  result_byte_fifo #(.DEPTH(DEPTH)) u_result_byte_fifo (
    .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_data(res_data),
    .temp_wr(temp_wr), .temp_data(temp_data), .cs_n(cs_n), .sclk(sclk),
    .edge_mode(edge_mode), .dout(dout), .level(level), .overflow(overflow)
  );

  // {edge_mode, value}
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 12'hABC}, {2'd1, 12'h5A3}, {2'd2, 12'hFFF},
    {2'd3, 12'h801}, {2'd3, 12'h07E}, {2'd0, 12'h000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] d);
    res_data = d; res_wr = 1'b1; tick(1); res_wr = 1'b0;
  endtask

  task automatic push_temp(input logic [11:0] d);
    temp_data = d; temp_wr = 1'b1; tick(1); temp_wr = 1'b0;
  endtask

  // clocks n bits in one CS frame; returns the bits MSB first and whether DOUT
  // held steady across every sampling edge
  task automatic read_bits(input int n, input logic [1:0] m,
                           output logic [15:0] v, output bit steady);
    logic b;
    v = '0; steady = 1;
    edge_mode = m;
    sclk = (m == 2'b11);
    tick(6);
    cs_n = 1'b0; tick(8);
    for (int i = 0; i < n; i++) begin
      b = dout;
      v = {v[14:0], b};
      sclk = ~sclk; tick(8);
      if (dout !== b) steady = 0;
      sclk = ~sclk; tick(8);
    end
    cs_n = 1'b1; tick(8);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit st;
    tick(4);
    // R10 reset state
    chk("R10 dout", dout, 0);
    chk("R10 level", level, 0);
    chk("R10 overflow", overflow, 0);
    rst_n = 1'b1; tick(2);

    // R1 R6 table walk
    foreach (VEC[k]) begin
      push(VEC[k][11:0]);
      read_bits(16, VEC[k][13:12], v, st);
      chk("R1 entry bytes", v, {4'h0, VEC[k][11:0]});
      chk("R6 launch edge hold", st, 1);
    end
    chk("R10 drained level", level, 0);

    // R9 DOUT low with CS high while data waits
    push(12'hFFF); tick(4);
    chk("R9 dout idle", dout, 0);
    // R11 empty frame consumes nothing
    edge_mode = 2'b00; sclk = 0; tick(4);
    cs_n = 1'b0; tick(20); cs_n = 1'b1; tick(8);
    read_bits(16, 2'b00, v, st);
    chk("R11 entry kept", v, 16'h0FFF);

    // R2 partial high byte
    push(12'h9C5); push(12'h3A7);
    chk("R10 level two", level, 2);
    read_bits(5, 2'b00, v, st);
    chk("R2 partial bits", v[4:0], 5'b00001);
    read_bits(8, 2'b00, v, st);
    chk("R2 next is low byte", v[7:0], 8'hC5);
    read_bits(16, 2'b00, v, st);
    chk("R2 following entry", v, 16'h03A7);

    // R3 partial low byte
    push(12'h6D2); push(12'h1B4);
    read_bits(11, 2'b11, v, st);
    chk("R3 partial low bits", v[10:0], {8'h06, 3'b110});
    chk("R3 level after cut", level, 1);
    read_bits(16, 2'b11, v, st);
    chk("R3 next entry", v, 16'h01B4);

    // R4 temperature first
    push(12'h111); push(12'h222);
    push_temp(12'hF38);
    read_bits(16, 2'b10, v, st);
    chk("R4 temp first", v, 16'h0F38);
    read_bits(16, 2'b10, v, st);
    chk("R4 then queue head", v, 16'h0111);
    read_bits(16, 2'b10, v, st);
    chk("R4 then second", v, 16'h0222);

    // R5 overwrite and single delivery
    push_temp(12'h0C8); push_temp(12'h190);
    read_bits(16, 2'b01, v, st);
    chk("R5 newest temp", v, 16'h0190);
    read_bits(16, 2'b01, v, st);
    chk("R5 no repeat", v, 16'h0000);

    // R8 empty read
    read_bits(16, 2'b00, v, st);
    chk("R8 empty zeros", v, 0);
    chk("R8 level unchanged", level, 0);

    // R7 fill past capacity
    for (int i = 0; i < DEPTH; i++) push(12'(i + 5));
    chk("R7 overflow clear at full", overflow, 0);
    push(12'hEEE); push(12'hDDD);
    chk("R7 level capped", level, DEPTH);
    chk("R7 overflow set", overflow, 1);
    read_bits(16, 2'b00, v, st);
    chk("R7 head intact", v, 16'h0005);
    chk("R7 level after read", level, DEPTH - 1);
    chk("R7 overflow sticky", overflow, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule